// File: doc/BRIEF.md
# Latched Bidirectional Byte Transceiver

This block connects two pad groups, side A and side B, and carries data between them in either direction. Each direction has a storage latch and three active-low controls: a direction gate, a latch strobe and an output gate. The datapath is split into `SECTIONS` independent byte lanes, which is two by default. Each lane has a full set of six controls, so the block can act as two byte transceivers or as one 16-bit transceiver when the lane controls are tied together.

Pads are modelled as separate signals instead of inout nets:

- a received value;
- a flag that says whether something outside drives the pad;
- a value the block presents;
- a per-lane drive enable.

Each pad group has a keeper register, so an undriven pad keeps the last value that was driven onto it. The latches are emulated on the system clock. Each latch is a two-state machine that follows the registered level of its strobe:

- `ST_SHUT`: the strobe was high last cycle.
- `ST_OPEN`: the strobe was low last cycle.

The machine makes two transitions:

- `ST_SHUT` goes to `ST_OPEN` when the strobe falls.
- `ST_OPEN` goes to `ST_SHUT` when the strobe rises. If the direction gate is low in that cycle, this is the capture event.

Top module: `latched_xcvr`

## Requirements
- R1: With a direction gate high (inactive), that direction never drives its destination pads and its latch keeps its contents, even if its strobe rises.
- R2: With the direction gate low and the strobe low, the latch is transparent: it loads the source byte every clock cycle, and an enabled destination presents the current source byte in the same cycle.
- R3: A rising strobe, seen as a low registered strobe and a high current strobe, with the direction gate low, captures the source byte present at that clock edge. The destination shows the old stored byte in the cycle of the rise and the captured byte from the next cycle on.
- R4: A destination lane drives (its drive enable is 1) only while both its direction gate and its output gate are low. It then presents the source byte if transparent and the stored byte otherwise.
- R5: With the output gate high, the destination is not driven, but the latch still goes transparent and captures as in R2 and R3.
- R6: The B-to-A direction behaves the same as A-to-B, under its own three controls.
- R7: Lane s uses data bits [8s+7:8s] and control bit s only; activity on one lane leaves the other unchanged.
- R8: Each pad group's keeper records the value driven onto each lane every cycle, by the block or by the outside. When a lane is not driven by the block, its pad output shows the keeper value.
- R9: Reset (rst_n low, asynchronous) clears both latches and both keepers of every lane to zero and puts both latch machines in ST_SHUT.
- R10: When both directions of one lane want to drive in the same cycle, the lane's clash bit is 1, A-to-B drives side B, and B-to-A drives nothing.
- R11: A source lane whose outside-drive flag is 0 supplies its keeper value to the latch instead of the received pad value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_ext | input | SECTIONS | Per lane: side A pads are driven from outside |
| a_pad_in | input | SECTIONS*LANE_W | Value received on side A |
| b_ext | input | SECTIONS | Per lane: side B pads are driven from outside |
| b_pad_in | input | SECTIONS*LANE_W | Value received on side B |
| ab_dir_n | input | SECTIONS | A-to-B direction gate, active low |
| ab_stb_n | input | SECTIONS | A-to-B latch strobe, active low |
| ab_out_n | input | SECTIONS | A-to-B output gate, active low |
| ba_dir_n | input | SECTIONS | B-to-A direction gate, active low |
| ba_stb_n | input | SECTIONS | B-to-A latch strobe, active low |
| ba_out_n | input | SECTIONS | B-to-A output gate, active low |
| a_pad_out | output | SECTIONS*LANE_W | Side A value: driven byte, or keeper value if undriven |
| a_pad_oe | output | SECTIONS | Side A drive enable per lane |
| b_pad_out | output | SECTIONS*LANE_W | Side B value: driven byte, or keeper value if undriven |
| b_pad_oe | output | SECTIONS | Side B drive enable per lane |
| clash | output | SECTIONS | Both directions of a lane requested drive |

## Verification
The bench targets the cycle in which the strobe rises. A design that captured one cycle late, or that showed the new byte in the rise cycle, would give the wrong destination byte in one of two adjacent samples. A strobe rise while the direction gate is high, followed by a quiet cycle, shows whether an unwanted capture happened: the byte presented afterwards would change. Loading with the outputs gated off proves the latch runs independently of drive, which a design that merged the two gates would miss. A lane where both directions request drive at once checks the priority and the clash flag. Releasing a pad checks that the keeper shows the last driven byte and not zero or a stale value.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    // Registered level of a latch strobe; drives the latch machine.
    typedef enum logic {
        ST_SHUT = 1'b0,
        ST_OPEN = 1'b1
    } latch_st_t;

    // Per-cycle latch action chosen from state and controls.
    typedef enum logic [1:0] {
        ACT_KEEP    = 2'd0,
        ACT_PASS    = 2'd1,
        ACT_CAPTURE = 2'd2
    } latch_act_t;
endpackage

// File: rtl/xcvr_latch.sv
module xcvr_latch
    import xcvr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_n,
    input  logic              stb_n,
    input  logic [LANE_W-1:0] src,
    output logic [LANE_W-1:0] view
);
    latch_st_t         state_q, state_d;
    latch_act_t        act;
    logic [LANE_W-1:0] store_q;

    // next state follows the strobe level
    assign state_d = stb_n ? ST_SHUT : ST_OPEN;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        act = ACT_KEEP;
        unique case (state_q)
            ST_SHUT: begin
                if (!dir_n && !stb_n) act = ACT_PASS;
            end
            ST_OPEN: begin
                if (!dir_n && !stb_n)     act = ACT_PASS;
                else if (!dir_n && stb_n) act = ACT_CAPTURE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  store_q <= '0;
        else if (act != ACT_KEEP)    store_q <= src;
    end

    assign view = (act == ACT_PASS) ? src : store_q;
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_drv,
    input  logic [LANE_W-1:0] own_val,
    input  logic              ext_drv,
    input  logic [LANE_W-1:0] ext_val,
    output logic [LANE_W-1:0] keep_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       keep_q <= '0;
        else if (own_drv) keep_q <= own_val;
        else if (ext_drv) keep_q <= ext_val;
    end
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr #(
    parameter int SECTIONS = 2,
    parameter int LANE_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SECTIONS-1:0]        a_ext,
    input  logic [SECTIONS*LANE_W-1:0] a_pad_in,
    input  logic [SECTIONS-1:0]        b_ext,
    input  logic [SECTIONS*LANE_W-1:0] b_pad_in,
    input  logic [SECTIONS-1:0]        ab_dir_n,
    input  logic [SECTIONS-1:0]        ab_stb_n,
    input  logic [SECTIONS-1:0]        ab_out_n,
    input  logic [SECTIONS-1:0]        ba_dir_n,
    input  logic [SECTIONS-1:0]        ba_stb_n,
    input  logic [SECTIONS-1:0]        ba_out_n,
    output logic [SECTIONS*LANE_W-1:0] a_pad_out,
    output logic [SECTIONS-1:0]        a_pad_oe,
    output logic [SECTIONS*LANE_W-1:0] b_pad_out,
    output logic [SECTIONS-1:0]        b_pad_oe,
    output logic [SECTIONS-1:0]        clash
);
    for (genvar s = 0; s < SECTIONS; s++) begin : g_lane
        localparam int LO = s * LANE_W;

        logic [LANE_W-1:0] a_keep, b_keep, a_src, b_src, ab_view, ba_view;
        logic              ab_want, ba_want, ab_drv, ba_drv;

        // source byte: outside driver if present, else the keeper
        assign a_src = a_ext[s] ? a_pad_in[LO +: LANE_W] : a_keep;
        assign b_src = b_ext[s] ? b_pad_in[LO +: LANE_W] : b_keep;

        xcvr_latch #(.LANE_W(LANE_W)) u_ab (
            .clk(clk), .rst_n(rst_n), .dir_n(ab_dir_n[s]), .stb_n(ab_stb_n[s]),
            .src(a_src), .view(ab_view)
        );
        xcvr_latch #(.LANE_W(LANE_W)) u_ba (
            .clk(clk), .rst_n(rst_n), .dir_n(ba_dir_n[s]), .stb_n(ba_stb_n[s]),
            .src(b_src), .view(ba_view)
        );

        // drive arbitration: A-to-B wins a clash
        assign ab_want = !ab_dir_n[s] && !ab_out_n[s];
        assign ba_want = !ba_dir_n[s] && !ba_out_n[s];
        assign ab_drv  = ab_want;
        assign ba_drv  = ba_want && !ab_want;
        assign clash[s] = ab_want && ba_want;

        xcvr_keeper #(.LANE_W(LANE_W)) u_keep_a (
            .clk(clk), .rst_n(rst_n), .own_drv(ba_drv), .own_val(ba_view),
            .ext_drv(a_ext[s]), .ext_val(a_pad_in[LO +: LANE_W]), .keep_q(a_keep)
        );
        xcvr_keeper #(.LANE_W(LANE_W)) u_keep_b (
            .clk(clk), .rst_n(rst_n), .own_drv(ab_drv), .own_val(ab_view),
            .ext_drv(b_ext[s]), .ext_val(b_pad_in[LO +: LANE_W]), .keep_q(b_keep)
        );

        assign a_pad_oe[s] = ba_drv;
        assign b_pad_oe[s] = ab_drv;
        assign a_pad_out[LO +: LANE_W] = ba_drv ? ba_view : a_keep;
        assign b_pad_out[LO +: LANE_W] = ab_drv ? ab_view : b_keep;
    end
endmodule

// File: rtl/latched_xcvr_checks.sv
module latched_xcvr_checks #(
    parameter int SECTIONS = 2,
    parameter int LANE_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [SECTIONS-1:0]        a_ext,
    input logic [SECTIONS*LANE_W-1:0] a_pad_in,
    input logic [SECTIONS-1:0]        b_ext,
    input logic [SECTIONS*LANE_W-1:0] b_pad_in,
    input logic [SECTIONS-1:0]        ab_dir_n,
    input logic [SECTIONS-1:0]        ab_stb_n,
    input logic [SECTIONS-1:0]        ab_out_n,
    input logic [SECTIONS-1:0]        ba_dir_n,
    input logic [SECTIONS-1:0]        ba_stb_n,
    input logic [SECTIONS-1:0]        ba_out_n,
    input logic [SECTIONS*LANE_W-1:0] a_pad_out,
    input logic [SECTIONS-1:0]        a_pad_oe,
    input logic [SECTIONS*LANE_W-1:0] b_pad_out,
    input logic [SECTIONS-1:0]        b_pad_oe,
    input logic [SECTIONS-1:0]        clash
);
    for (genvar s = 0; s < SECTIONS; s++) begin : g_chk
        localparam int LO = s * LANE_W;

        p_drive_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
            b_pad_oe[s] |-> (!ab_dir_n[s] && !ab_out_n[s]));

        p_dir_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ba_dir_n[s] |-> !a_pad_oe[s]);

        p_back_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
            a_pad_oe[s] |-> (!ba_dir_n[s] && !ba_out_n[s] && !clash[s]));

        p_clash_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
            clash[s] |-> (b_pad_oe[s] && !a_pad_oe[s]));

        p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (b_pad_oe[s] && !ab_stb_n[s] && a_ext[s])
            |-> (b_pad_out[LO +: LANE_W] == a_pad_in[LO +: LANE_W]));

        p_keeper_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!b_pad_oe[s] && $past(!b_pad_oe[s] && !b_ext[s]))
            |-> $stable(b_pad_out[LO +: LANE_W]));
    end
endmodule

bind latched_xcvr latched_xcvr_checks #(.SECTIONS(SECTIONS), .LANE_W(LANE_W)) u_checks (.*);

// File: tb/latched_xcvr_bench.sv
module latched_xcvr_bench;
    localparam int S = 2;
    localparam int L = 8;
    localparam int NV = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [S-1:0]   a_ext = '0, b_ext = '0;
    logic [S*L-1:0] a_pad_in = '0, b_pad_in = '0;
    logic [S-1:0]   ab_dir_n = '1, ab_stb_n = '1, ab_out_n = '1;
    logic [S-1:0]   ba_dir_n = '1, ba_stb_n = '1, ba_out_n = '1;
    logic [S*L-1:0] a_pad_out, b_pad_out;
    logic [S-1:0]   a_pad_oe, b_pad_oe, clash;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    latched_xcvr #(.SECTIONS(S), .LANE_W(L)) u_latched_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_ext(a_ext), .a_pad_in(a_pad_in), .b_ext(b_ext), .b_pad_in(b_pad_in),
        .ab_dir_n(ab_dir_n), .ab_stb_n(ab_stb_n), .ab_out_n(ab_out_n),
        .ba_dir_n(ba_dir_n), .ba_stb_n(ba_stb_n), .ba_out_n(ba_out_n),
        .a_pad_out(a_pad_out), .a_pad_oe(a_pad_oe),
        .b_pad_out(b_pad_out), .b_pad_oe(b_pad_oe), .clash(clash)
    );

    // lane 0 A-to-B: {dir_n, stb_n, out_n, a byte, expected oe, expected b byte}
    localparam logic [19:0] VEC [NV] = '{
        {3'b100, 8'h11, 1'b0, 8'h00},   // R1 gate off, keeper zero
        {3'b000, 8'h22, 1'b1, 8'h22},   // R2 transparent
        {3'b000, 8'h33, 1'b1, 8'h33},   // R2 follows
        {3'b010, 8'h44, 1'b1, 8'h33},   // R3 rise cycle: old byte
        {3'b010, 8'h55, 1'b1, 8'h44},   // R3 captured byte held
        {3'b011, 8'h66, 1'b0, 8'h44},   // R5 outputs off
        {3'b001, 8'h77, 1'b0, 8'h44},   // R5 loading while off
        {3'b011, 8'h88, 1'b0, 8'h44},   // R5 capture while off
        {3'b010, 8'h99, 1'b1, 8'h88},   // R5 loaded byte appears
        {3'b100, 8'hAA, 1'b0, 8'h88},   // R1 gate off
        {3'b110, 8'hBB, 1'b0, 8'h88},   // R1 strobe rise, gate off
        {3'b010, 8'hCC, 1'b1, 8'h88}    // R1 no capture happened
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 9, 10, 11: return "R1";
            1, 2:         return "R2";
            3, 4:         return "R3";
            default:      return "R5";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        ab_dir_n = '1; ab_stb_n = '1; ab_out_n = '1;
        ba_dir_n = '1; ba_stb_n = '1; ba_out_n = '1;
        a_ext = '0; b_ext = '0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #4;
        // R9 reset state
        chk("R9 a_oe", 32'(a_pad_oe), 0);
        chk("R9 b_oe", 32'(b_pad_oe), 0);
        chk("R9 b_out", 32'(b_pad_out), 0);
        chk("R9 clash", 32'(clash), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk on lane 0; lane 1 idle (R7)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {ab_dir_n[0], ab_stb_n[0], ab_out_n[0]} = VEC[i][19:17];
            a_ext[0] = 1'b1;
            a_pad_in[7:0] = VEC[i][16:9];
            #4;
            chk(vec_tag(i), 32'(b_pad_oe[0]), 32'(VEC[i][8]));
            chk(vec_tag(i), 32'(b_pad_out[7:0]), 32'(VEC[i][7:0]));
            chk("R7 lane1 quiet", 32'(b_pad_oe[1]), 0);
        end

        // R6 R7: B-to-A on lane 1, lane 0 off
        @(negedge clk);
        idle_all();
        b_ext[1] = 1'b1; b_pad_in[15:8] = 8'h5A;
        ba_dir_n[1] = 1'b0; ba_stb_n[1] = 1'b0; ba_out_n[1] = 1'b0;
        #4;
        chk("R6 a_oe", 32'(a_pad_oe), 32'h2);
        chk("R6 a_out", 32'(a_pad_out[15:8]), 32'h5A);
        chk("R7 lane0 b_oe", 32'(b_pad_oe), 0);
        chk("R7 lane0 b_out", 32'(b_pad_out[7:0]), 32'h88);

        // R8: release both sides of lane 1
        @(negedge clk);
        b_ext[1] = 1'b0; ba_out_n[1] = 1'b1;
        #4;
        chk("R8 a_oe", 32'(a_pad_oe[1]), 0);
        chk("R8 a keep", 32'(a_pad_out[15:8]), 32'h5A);
        chk("R8 b keep", 32'(b_pad_out[15:8]), 32'h5A);

        // R11: A-to-B sources from A keeper
        @(negedge clk);
        ba_dir_n[1] = 1'b1; ba_stb_n[1] = 1'b1;
        ab_dir_n[1] = 1'b0; ab_stb_n[1] = 1'b0; ab_out_n[1] = 1'b0;
        #4;
        chk("R11 b_oe", 32'(b_pad_oe[1]), 1);
        chk("R11 b_out", 32'(b_pad_out[15:8]), 32'h5A);

        // R10: both directions of lane 1 request drive
        @(negedge clk);
        a_ext[1] = 1'b1; a_pad_in[15:8] = 8'hC3;
        ba_dir_n[1] = 1'b0; ba_stb_n[1] = 1'b0; ba_out_n[1] = 1'b0;
        #4;
        chk("R10 clash", 32'(clash), 32'h2);
        chk("R10 b_out", 32'(b_pad_out[15:8]), 32'hC3);
        chk("R10 a_oe", 32'(a_pad_oe[1]), 0);
        chk("R10 a keep", 32'(a_pad_out[15:8]), 32'h5A);

        @(negedge clk);
        ba_out_n[1] = 1'b1;
        #4;
        chk("R10 clash clears", 32'(clash), 0);

        // R9: reset mid-run clears keepers
        @(negedge clk);
        idle_all();
        rst_n = 1'b0;
        #4;
        chk("R9 a keep", 32'(a_pad_out), 0);
        chk("R9 b keep", 32'(b_pad_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 latch cleared: lane 0 A-to-B drives stored byte with strobe high
        @(negedge clk);
        ab_dir_n[0] = 1'b0; ab_out_n[0] = 1'b0;
        #4;
        chk("R9 latch zero", 32'(b_pad_out[7:0]), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule